// File: doc/BRIEF.md
# Fall-Through Shift-Register FIFO

This block is a first-in-first-out queue built as a column of data cells in which the stored words physically move. The cells are numbered from 0 at the top to DEPTH-1 at the bottom. A word that is accepted is placed in the free cell with the highest index, so it appears to drop through the empty cells in one clock. The consumer only ever sees the bottom cell. Removing that word moves every stored word one cell further down.

An occupancy counter decides where an incoming word lands. It drives the empty and full flags, and it refuses writes that have nowhere to go. The write and read strobes are independent of each other and share one clock. A rejected write or read is dropped, and it raises a one-cycle overflow or underflow pulse on the following cycle.

The block sits between a producer and a consumer in one clock domain. It suits small depths where a read port that needs no address decode is worth the cost of moving words.

Top module: `ftf_queue`

## Requirements
- R1: While reset is held, and after it is released, the queue is empty: `level` is 0, `empty` is 1, and `full`, `rd_valid`, `overflow` and `underflow` are 0.
- R2: A word written into an empty queue shows on `rd_data` with `rd_valid` high in the cycle after the write strobe, and `level` becomes 1.
- R3: Words leave in the order they were accepted, and every accepted write that has no accepted read in the same cycle raises `level` by one.
- R4: An accepted read removes the bottom word. The next older word appears on `rd_data` in the following cycle, and `level` drops by one.
- R5: When `level` equals DEPTH, `full` is 1. A write without a read in that state is ignored: `level` and the stored words stay unchanged.
- R6: A read strobe on an empty queue is ignored, and `underflow` is 1 for exactly the following cycle.
- R7: `overflow` is 1 for exactly the cycle after a rejected write and is 0 at every other time.
- R8: A read and a write in the same cycle on a queue that is neither empty nor full leave `level` unchanged, advance the output to the next word, and keep the order.
- R9: A read and a write in the same cycle on a full queue are both accepted. `level` stays at DEPTH and `overflow` stays 0.
- R10: A read and a write in the same cycle on an empty queue reject the read (with an `underflow` pulse) and accept the write, so `level` becomes 1.
- R11: `rd_valid` is 1 exactly when `empty` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Word to enqueue |
| rd_en | input | 1 | Removing-read strobe |
| rd_data | output | DATA_W | Content of the bottom cell |
| rd_valid | output | 1 | Bottom cell holds a word |
| level | output | $clog2(DEPTH+1) | Number of stored words |
| empty | output | 1 | No word stored |
| full | output | 1 | DEPTH words stored |
| overflow | output | 1 | One-cycle pulse after a rejected write |
| underflow | output | 1 | One-cycle pulse after a rejected read |

## Verification
A wrong landing index, or a shift that fails to fire, leaves a gap or duplicates a word inside the column. That fault is not visible until the affected word reaches the bottom. The ports then show a wrong `rd_data`, or `rd_valid` disagreeing with `empty`, up to `level` reads later. For this reason every scenario drains the queue completely and compares each word against an order model. A counter fault shows up in `level`, `full` and the pulse flags in the very next cycle, so these are compared after every clock.

// File: rtl/ftf_pkg.sv
package ftf_pkg;

  // Accepted operation of one cycle, encoded as {write_ok, read_ok}
  typedef enum logic [1:0] {
    FTF_IDLE = 2'b00,
    FTF_POP  = 2'b01,
    FTF_PUSH = 2'b10,
    FTF_SWAP = 2'b11
  } ftf_op_e;

endpackage

// File: rtl/ftf_rst_sync.sv
module ftf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/ftf_ctrl.sv
module ftf_ctrl
  import ftf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  output logic             load_o,
  output logic             shift_o,
  output logic [IDX_W-1:0] load_idx_o,
  output logic [CNT_W-1:0] count_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             ovf_o,
  output logic             unf_o
);

  logic [CNT_W-1:0] count_q, count_d, slot;
  logic             cnt_en;
  logic             rd_ok, wr_ok;
  logic             ovf_q, ovf_d, unf_q, unf_d;
  ftf_op_e          op;

  // Decode the accepted operation
  always_comb begin
    empty_o = (count_q == '0);
    full_o  = (count_q == CNT_W'(DEPTH));
    rd_ok   = rd_en_i && !empty_o;
    wr_ok   = wr_en_i && (!full_o || rd_ok);
    op      = ftf_op_e'({wr_ok, rd_ok});
    ovf_d   = wr_en_i && !wr_ok;
    unf_d   = rd_en_i && !rd_ok;
  end

  // Next count and landing slot of an incoming word
  always_comb begin
    count_d = count_q;
    cnt_en  = 1'b0;
    slot    = CNT_W'(DEPTH - 1) - count_q;
    case (op)
      FTF_PUSH: begin
        count_d = count_q + CNT_W'(1);
        cnt_en  = 1'b1;
      end
      FTF_POP: begin
        count_d = count_q - CNT_W'(1);
        cnt_en  = 1'b1;
      end
      FTF_SWAP: slot = CNT_W'(DEPTH) - count_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (cnt_en) begin
      count_q <= count_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  assign load_o     = wr_ok;
  assign shift_o    = rd_ok;
  assign load_idx_o = slot[IDX_W-1:0];
  assign count_o    = count_q;
  assign ovf_o      = ovf_q;
  assign unf_o      = unf_q;

  // R5: a lone write on a full queue changes nothing and is reported
  a_r5_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && wr_en_i && !rd_en_i) |=> ($stable(count_q) && ovf_q));

  // R6: a lone read on an empty queue changes nothing and is reported
  a_r6_empty_read_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && rd_en_i && !wr_en_i) |=> (count_q == '0 && unf_q));

  // R7: no overflow pulse without a rejected write
  a_r7_no_spurious_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_o && wr_en_i && !rd_en_i) |=> !ovf_q);

  // R8: a simultaneous read and write keep the level
  a_r8_swap_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_o && wr_en_i && rd_en_i) |=> $stable(count_q));

endmodule

// File: rtl/ftf_cell.sv
module ftf_cell #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] up_data_i,
  input  logic              up_vld_i,
  output logic [DATA_W-1:0] data_o,
  output logic              vld_o
);

  logic [DATA_W-1:0] data_q, data_d;
  logic              vld_q, vld_d, data_en;

  // A load has priority: during a swap the loaded cell is the one the shift emptied
  always_comb begin
    data_d  = data_q;
    vld_d   = vld_q;
    data_en = 1'b0;
    if (load_i) begin
      data_d  = wdata_i;
      vld_d   = 1'b1;
      data_en = 1'b1;
    end else if (shift_i) begin
      data_d  = up_data_i;
      vld_d   = up_vld_i;
      data_en = 1'b1;
    end
  end

  // Data has no reset; vld_q qualifies it
  always_ff @(posedge clk) begin
    if (data_en) data_q <= data_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  assign data_o = data_q;
  assign vld_o  = vld_q;

endmodule

// File: rtl/ftf_queue.sv
module ftf_queue #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [CNT_W-1:0]  level,
  output logic              empty,
  output logic              full,
  output logic              overflow,
  output logic              underflow
);

  logic              rst_n_s;
  logic              load, shift;
  logic [IDX_W-1:0]  load_idx;
  logic [DATA_W-1:0] cdata [DEPTH];
  logic [DEPTH-1:0]  cvld;

  ftf_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_s)
  );

  ftf_ctrl #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W),
    .IDX_W (IDX_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .wr_en_i    (wr_en),
    .rd_en_i    (rd_en),
    .load_o     (load),
    .shift_o    (shift),
    .load_idx_o (load_idx),
    .count_o    (level),
    .empty_o    (empty),
    .full_o     (full),
    .ovf_o      (overflow),
    .unf_o      (underflow)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic [DATA_W-1:0] up_data;
    logic              up_vld;

    if (i == 0) begin : g_top
      assign up_data = '0;
      assign up_vld  = 1'b0;
    end else begin : g_inner
      assign up_data = cdata[i-1];
      assign up_vld  = cvld[i-1];
      // R4: stored words stay packed against the bottom cell
      a_r4_packed: assert property (@(posedge clk) disable iff (!rst_n_s)
        cvld[i-1] |-> cvld[i]);
    end

    ftf_cell #(.DATA_W(DATA_W)) u_cell (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .shift_i   (shift),
      .load_i    (load && (load_idx == IDX_W'(i))),
      .wdata_i   (wr_data),
      .up_data_i (up_data),
      .up_vld_i  (up_vld),
      .data_o    (cdata[i]),
      .vld_o     (cvld[i])
    );
  end

  assign rd_data  = cdata[DEPTH-1];
  assign rd_valid = cvld[DEPTH-1];

  // R3: occupied cells and the counter agree
  a_r3_occupancy: assert property (@(posedge clk) disable iff (!rst_n_s)
    $countones(cvld) == int'(level));

  // R11: bottom cell valid matches the counter's empty flag
  a_r11_valid_tracks_level: assert property (@(posedge clk) disable iff (!rst_n_s)
    rd_valid == !empty);

  // R2: a word written to an empty queue is readable one cycle later
  a_r2_fall_through: assert property (@(posedge clk) disable iff (!rst_n_s)
    (empty && wr_en) |=> (rd_valid && rd_data == $past(wr_data)));

endmodule

// File: tb/sim_ftf_queue.sv
module sim_ftf_queue;

  localparam int W = 8;
  localparam int D = 8;
  localparam int CW = $clog2(D + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, rd_en;
  logic [W-1:0]  wr_data;
  logic [W-1:0]  rd_data;
  logic          rd_valid, empty, full, overflow, underflow;
  logic [CW-1:0] level;

  int nchk  = 0;
  int nfail = 0;
  logic [W-1:0] mq[$];

  always #2 clk = ~clk;

  ftf_queue #(.DATA_W(W), .DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .level(level), .empty(empty),
    .full(full), .overflow(overflow), .underflow(underflow)
  );

  task automatic chk(string tag, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic cmp_all(string tag, bit e_ovf, bit e_unf);
    int n = mq.size();
    chk(tag, "level", int'(level), n);
    chk(tag, "empty", int'(empty), int'(n == 0));
    chk(tag, "full", int'(full), int'(n == D));
    chk({tag, "/R11"}, "rd_valid", int'(rd_valid), int'(n != 0));
    if (n != 0) chk({tag, "/R3"}, "rd_data", int'(rd_data), int'(mq[0]));
    chk({tag, "/R7"}, "overflow", int'(overflow), int'(e_ovf));
    chk({tag, "/R6"}, "underflow", int'(underflow), int'(e_unf));
  endtask

  // One clock with the given strobes; the model follows the requirements
  task automatic cyc(string tag, bit w, logic [W-1:0] d, bit r);
    int  n     = mq.size();
    bit  rd_ok = r && (n > 0);
    bit  wr_ok = w && ((n < D) || rd_ok);
    wr_en   = w;
    wr_data = d;
    rd_en   = r;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    rd_en = 1'b0;
    if (rd_ok) void'(mq.pop_front());
    if (wr_ok) mq.push_back(d);
    cmp_all(tag, w && !wr_ok, r && !rd_ok);
  endtask

  task automatic drain(string tag);
    while (mq.size() != 0) cyc(tag, 1'b0, '0, 1'b1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    wr_en = 1'b0;
    rd_en = 1'b0;
    wr_data = '0;
    mq.delete();
    repeat (3) @(posedge clk);
    #1;
    cmp_all("R1 in reset", 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    cmp_all("R1 after release", 1'b0, 1'b0);
  endtask

  task automatic t_first_write();
    cyc("R2 first write", 1'b1, 8'hA5, 1'b0);
    chk("R2", "rd_data", int'(rd_data), 'hA5);
    cyc("R2 second write", 1'b1, 8'h3C, 1'b0);
    drain("R4 drain");
  endtask

  task automatic t_fill_full();
    for (int i = 0; i < D; i++) cyc("R3 fill", 1'b1, 8'(8'h10 + i), 1'b0);
    chk("R5", "full", int'(full), 1);
    cyc("R5 write on full", 1'b1, 8'hEE, 1'b0);
    cyc("R7 pulse clears", 1'b0, '0, 1'b0);
    cyc("R5 second write on full", 1'b1, 8'hDD, 1'b0);
    drain("R4 drain after full");
  endtask

  task automatic t_underflow();
    cyc("R6 read on empty", 1'b0, '0, 1'b1);
    cyc("R6 pulse clears", 1'b0, '0, 1'b0);
    cyc("R6 read on empty again", 1'b0, '0, 1'b1);
  endtask

  task automatic t_swap();
    for (int i = 0; i < 3; i++) cyc("R8 prefill", 1'b1, 8'(8'h40 + i), 1'b0);
    for (int i = 0; i < 6; i++) cyc("R8 swap", 1'b1, 8'(8'h60 + i), 1'b1);
    drain("R8 drain");
  endtask

  task automatic t_full_swap();
    for (int i = 0; i < D; i++) cyc("R9 prefill", 1'b1, 8'(8'h80 + i), 1'b0);
    cyc("R9 swap on full", 1'b1, 8'hC1, 1'b1);
    cyc("R9 swap on full again", 1'b1, 8'hC2, 1'b1);
    drain("R9 drain");
  endtask

  task automatic t_empty_swap();
    cyc("R10 swap on empty", 1'b1, 8'h77, 1'b1);
    drain("R10 drain");
  endtask

  task automatic t_mixed();
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc("R3 mixed", lfsr[0] | lfsr[3], lfsr[15:8], lfsr[1] & lfsr[5]);
    end
    drain("R4 mixed drain");
  endtask

  initial begin
    t_reset();
    t_first_write();
    t_fill_full();
    t_underflow();
    t_swap();
    t_full_swap();
    t_empty_swap();
    t_mixed();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #800000;
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule